// File: doc/BRIEF.md
# Dual-Bus Transmitter Shutdown Controller

This block owns the enable lines of the two redundant bus transceivers (bus A and bus B) in a command/response remote terminal. A command decoder upstream sends a one-cycle pulse when it has validated a transmitter-shutdown-type mode command, or a matching override command. With each pulse it also sends the bus on which the command arrived. The block acts on the other bus, the inactive one. For that bus it either silences the transmitter alone or turns off both the transmitter and the receiver.

Two configuration bits select the behaviour. While `manual_sd` is 1, automatic handling is off and the pulses leave the enables unchanged. While `manual_sd` is 0, `mute_sel` chooses the action. At 0 it selects full shutdown of the inactive bus. At 1 it selects a muted terminal: the inactive bus still receives, and the terminal still obeys commands and stores data from that bus, but it never transmits status or data on it. Both bits are expected at 0 after master reset, which makes full shutdown the default. Built-in-test flags show the shutdown state of each bus while automatic handling is on.

Top module: `bus_txoff_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it rises with no command, every transmitter and receiver enable is 1 and every built-in-test flag is 0.
- R2: With `manual_sd`=0 and `mute_sel`=0, a `sd_pulse` clears both `tx_en` and `rx_en` of the inactive bus on the next clock edge. The bus that carried the command is left unchanged.
- R3: With `manual_sd`=0 and `mute_sel`=1, a `sd_pulse` clears only `tx_en` of the inactive bus on the next edge. Its `rx_en` keeps its previous value.
- R4: While `manual_sd`=1, neither `sd_pulse` nor `ovr_pulse` changes any enable.
- R5: `bit_tx_off[i]` equals the inverse of `tx_en[i]`, and `bit_rx_off[i]` equals the inverse of `rx_en[i]`, while `manual_sd`=0. Both flag vectors read all zeros while `manual_sd`=1.
- R6: With `manual_sd`=0, an `ovr_pulse` without `sd_pulse` sets both `tx_en` and `rx_en` of the inactive bus to 1 on the next edge.
- R7: With no pulse, every enable holds its value from cycle to cycle.
- R8: If `sd_pulse` and `ovr_pulse` are both high in the same cycle, the shutdown is applied and the override is ignored.
- R9: `cmd_bus`=0 means the command came on bus A and `cmd_bus`=1 means bus B. Index 0 of each vector is bus A and index 1 is bus B, so the bus acted on has index `!cmd_bus`.
- R10: A receiver is never disabled while the transmitter on the same bus is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low master reset |
| manual_sd | input | 1 | 1 = automatic shutdown off |
| mute_sel | input | 1 | 1 = mute (transmitter only), 0 = full bus shutdown |
| sd_pulse | input | 1 | Valid shutdown mode command, one cycle |
| ovr_pulse | input | 1 | Valid override mode command, one cycle |
| cmd_bus | input | 1 | Bus that carried the command (0 = A, 1 = B) |
| tx_en | output | 2 | Transmitter enables [B,A] |
| rx_en | output | 2 | Receiver enables [B,A] |
| bit_tx_off | output | 2 | Built-in-test transmitter-shutdown flags [B,A] |
| bit_rx_off | output | 2 | Built-in-test receiver-shutdown flags [B,A] |

## Verification
The bench sweeps every combination of configuration, pulses and command bus, starting from three prior shutdown states. Several faults are targeted. A design that acts on the commanding bus instead of the other one fails the bus-index checks. A design that drops the receiver in mute mode, or that re-enables a receiver already shut down by an earlier full shutdown, breaks the mute checks. A design that lets an override beat a coincident shutdown, or that acts while automatic handling is off, shows the wrong enables on the next cycle. A design whose flags stay live while automatic handling is off, or that releases state without an override, is caught by the flag checks and the idle-cycle checks.

// File: rtl/bus_txoff_ctrl.sv
module bus_txoff_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       manual_sd,
  input  logic       mute_sel,
  input  logic       sd_pulse,
  input  logic       ovr_pulse,
  input  logic       cmd_bus,
  output logic [1:0] tx_en,
  output logic [1:0] rx_en,
  output logic [1:0] bit_tx_off,
  output logic [1:0] bit_rx_off
);

  logic [1:0] tx_off_q, rx_off_q;
  logic [1:0] target;
  logic       auto_on;

  assign auto_on = !manual_sd;
  assign target  = cmd_bus ? 2'b01 : 2'b10;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_off_q <= 2'b00;
      rx_off_q <= 2'b00;
    end else if (auto_on && sd_pulse) begin
      tx_off_q <= tx_off_q | target;
      if (!mute_sel) rx_off_q <= rx_off_q | target;
    end else if (auto_on && ovr_pulse) begin
      tx_off_q <= tx_off_q & ~target;
      rx_off_q <= rx_off_q & ~target;
    end
  end

  assign tx_en      = ~tx_off_q;
  assign rx_en      = ~rx_off_q;
  assign bit_tx_off = auto_on ? tx_off_q : 2'b00;
  assign bit_rx_off = auto_on ? rx_off_q : 2'b00;

  AST_MANUAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    manual_sd |=> ($stable(tx_en) && $stable(rx_en))); // R4
  AST_FULL_SD_A: assert property (@(posedge clk) disable iff (!rst_n)
    (!manual_sd && sd_pulse && !mute_sel && !cmd_bus) |=> (!tx_en[1] && !rx_en[1])); // R2
  AST_FULL_SD_B: assert property (@(posedge clk) disable iff (!rst_n)
    (!manual_sd && sd_pulse && !mute_sel && cmd_bus) |=> (!tx_en[0] && !rx_en[0])); // R2
  AST_MUTE_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (!manual_sd && sd_pulse && mute_sel) |=> $stable(rx_en)); // R3
  AST_KEEP_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_pulse && !cmd_bus) |=> ($stable(tx_en[0]) && $stable(rx_en[0]))); // R9
  AST_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (!manual_sd && ovr_pulse && !sd_pulse && cmd_bus) |=> (tx_en[0] && rx_en[0])); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sd_pulse && !ovr_pulse) |=> ($stable(tx_en) && $stable(rx_en))); // R7
  AST_RX_NEEDS_TX_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en[0] |-> !tx_en[0]) and (!rx_en[1] |-> !tx_en[1])); // R10

endmodule

// File: tb/bus_txoff_ctrl_bench.sv
module bus_txoff_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic manual_sd = 1'b0, mute_sel = 1'b0, sd_pulse = 1'b0, ovr_pulse = 1'b0, cmd_bus = 1'b0;
  logic [1:0] tx_en, rx_en, bit_tx_off, bit_rx_off;
  logic [1:0] m_tx, m_rx;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bus_txoff_ctrl u_bus_txoff_ctrl (
    .clk(clk), .rst_n(rst_n), .manual_sd(manual_sd), .mute_sel(mute_sel),
    .sd_pulse(sd_pulse), .ovr_pulse(ovr_pulse), .cmd_bus(cmd_bus),
    .tx_en(tx_en), .rx_en(rx_en), .bit_tx_off(bit_tx_off), .bit_rx_off(bit_rx_off));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic [1:0] ftx, frx;
    chk(tag, {4'b0, tx_en, rx_en}, {4'b0, m_tx, m_rx});
    ftx = manual_sd ? 2'b00 : ~m_tx;
    frx = manual_sd ? 2'b00 : ~m_rx;
    chk("R5", {4'b0, bit_tx_off, bit_rx_off}, {4'b0, ftx, frx});
    chk("R10", {6'b0, rx_en | ~tx_en}, 8'h03);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sd_pulse = 1'b0; ovr_pulse = 1'b0;
    manual_sd = 1'b0; mute_sel = 1'b0; cmd_bus = 1'b0;
    m_tx = 2'b11; m_rx = 2'b11;
    @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");
  endtask

  task automatic step(input logic man, input logic mute, input logic sd,
                      input logic ovr, input logic bus);
    logic [1:0] tgt;
    string tag;
    @(negedge clk);
    manual_sd = man; mute_sel = mute; sd_pulse = sd; ovr_pulse = ovr; cmd_bus = bus;
    tgt = bus ? 2'b01 : 2'b10;
    if (!man && sd) begin
      m_tx = m_tx & ~tgt;
      if (!mute) m_rx = m_rx & ~tgt;
    end else if (!man && ovr) begin
      m_tx = m_tx | tgt;
      m_rx = m_rx | tgt;
    end
    if (man) tag = "R4";
    else if (sd && ovr) tag = "R8";
    else if (sd && mute) tag = "R3";
    else if (sd) tag = "R2";
    else if (ovr) tag = "R6";
    else tag = "R7";
    @(negedge clk);
    sd_pulse = 1'b0; ovr_pulse = 1'b0;
    check_all(tag);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R9", {4'b0, tx_en, rx_en}, {4'b0, 2'b01, 2'b01});
    do_reset();
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
    chk("R9", {4'b0, tx_en, rx_en}, {4'b0, 2'b10, 2'b11});
    for (int pre = 0; pre < 3; pre++) begin
      for (int c = 0; c < 32; c++) begin
        do_reset();
        if (pre == 1) step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        if (pre == 2) step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
        step(c[4], c[3], c[2], c[1], c[0]);
        step(c[4], c[3], 1'b0, 1'b0, c[0]);
        step(1'b0, 1'b1, 1'b1, 1'b0, ~c[0]);
        step(c[4], 1'b0, 1'b0, 1'b1, c[0]);
      end
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule